// File: doc/BRIEF.md
# Multi-core interrupt distributor

This block gathers every interrupt source of a small processor cluster (two to four cores) and hands each core the most urgent interrupt that is pending, enabled and aimed at it. It presents that interrupt's number beside a per-core request line. Sources come in three groups. Each core has sixteen banked software interrupts. Each core also has five private lines: a global timer, a private timer, a watchdog and two legacy request pins. The third group is a bus of shared peripheral lines, which every core can be targeted by.

Software programs the block through a single-cycle write port. Through it, software sets priorities, enables, target masks, trigger mode and per-core interface enables, and raises software interrupts. Each core claims its interrupt with an acknowledge pulse, which returns the claimed number one cycle later. It releases the interrupt with an end-of-interrupt pulse that carries the number. While a core's interface is disabled, the legacy IRQ pin drives that core's request line directly. All inputs are taken to be synchronous to the block clock.

Write selectors on `cfgSel`: 0 priority, 1 enable, 2 target mask, 3 trigger mode, 4 software interrupt, 5 interface enable. `cfgCore` selects the bank for the per-core numbers (0–15, 27–31) and for the interface enable.

Top module: `irq_distributor`

## Requirements
- R1: After reset, every interface is disabled, every source is disabled with priority 0 and level trigger, each `ackId` reads 1023 and each `coreIrqId` reads 1023.
- R2: While a core's interface is disabled, its `coreIrq` equals its `legacyIrq` input. Once the interface is enabled, the legacy line raises a request only as source 31, and only when that source is enabled.
- R3: A core is offered the eligible source with the smallest priority value. When priorities are equal, the smaller number wins.
- R4: A software write (selector 4, number in `cfgId[3:0]`, receiving-core mask in `cfgData`) makes that number pending on each core in the mask. Each receiving core ranks it by its own banked priority, whatever the writer's `cfgCore` is.
- R5: The private lines are level-sensitive and map to fixed numbers: global timer 27, legacy FIQ 28, private timer 29, watchdog 30, legacy IRQ 31.
- R6: Shared line j is number 32+j. In edge mode (selector 3, `cfgData[0]`=1) a rising edge makes it pending. In level mode it is pending exactly while the line is high and the source is not active.
- R7: A shared source is offered only to the lowest-numbered target core that has its interface enabled and no active interrupt. After that core acknowledges it, no other core is offered it.
- R8: An acknowledge while a request is shown makes the offered number active, returns it on `ackId` after the clock edge, and lowers that core's request until its end-of-interrupt.
- R9: An acknowledge while no request is shown returns 1023 on `ackId`.
- R10: End-of-interrupt frees the source. A level source still high, or an edge source that saw a new rising edge while active, is offered again on the next cycle.
- R11: A source that is disabled, or a shared source whose target mask is zero, is never offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiIn | input | NUM_SPI | Shared peripheral interrupt lines |
| glbTimer | input | NUM_CORES | Global timer line per core (27) |
| legacyFiq | input | NUM_CORES | Legacy FIQ line per core (28) |
| privTimer | input | NUM_CORES | Private timer line per core (29) |
| wdogIrq | input | NUM_CORES | Watchdog line per core (30) |
| legacyIrq | input | NUM_CORES | Legacy IRQ line per core (31, bypass) |
| cfgWe | input | 1 | Configuration write strobe |
| cfgCore | input | CORE_W | Bank / writing core select |
| cfgSel | input | 3 | Write selector |
| cfgId | input | 10 | Interrupt number addressed |
| cfgData | input | 8 | Write data |
| ackReq | input | NUM_CORES | Acknowledge pulse per core |
| eoiReq | input | NUM_CORES | End-of-interrupt pulse per core |
| eoiIdIn | input | NUM_CORES*10 | Number being ended, 10 bits per core |
| coreIrq | output | NUM_CORES | Interrupt request per core |
| coreIrqId | output | NUM_CORES*10 | Offered number per core, 1023 if none |
| ackId | output | NUM_CORES*10 | Number claimed by the last acknowledge |

## Verification
The hardest situation to reach is a shared edge interrupt that is active on one core while a fresh edge arrives and the lower-numbered core becomes idle again. To build it, the bench first parks core 0 on a software interrupt, so the shared pulse lands on core 1. Core 1 acknowledges, core 0 is released, and a second pulse follows. The bench checks that core 0 is not offered the source until core 1 ends it, and that core 0 is offered it right after. Banked software priority is checked by giving the two banks opposite orderings, so that reading the sender's bank would pick a different number.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int ID_W     = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam int SGI_N    = 16;
  localparam int PPI_N    = 5;
  localparam int PPI_BASE = 27;
  localparam int SPI_BASE = 32;

  typedef enum logic [2:0] {
    SEL_PRIO   = 3'd0,
    SEL_ENABLE = 3'd1,
    SEL_TARGET = 3'd2,
    SEL_TRIG   = 3'd3,
    SEL_SGI    = 3'd4,
    SEL_IFACE  = 3'd5
  } cfgSel_e;

  // per-core strobes from control to datapath
  typedef struct packed {
    logic             ack;
    logic             eoi;
    logic [ID_W-1:0]  eoiId;
    logic [SGI_N-1:0] sgiSet;
  } coreStrobe_t;
endpackage

// File: rtl/irqd_ctrl.sv
module irqd_ctrl
  import irqd_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int NUM_SPI   = 8,
  parameter int PRIO_W    = 4,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int SPI_IW   = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgWe,
  input  logic [CORE_W-1:0] cfgCore,
  input  logic [2:0] cfgSel,
  input  logic [ID_W-1:0] cfgId,
  input  logic [7:0] cfgData,
  input  logic [NUM_CORES-1:0] ackReq,
  input  logic [NUM_CORES-1:0] eoiReq,
  input  logic [NUM_CORES*ID_W-1:0] eoiIdIn,
  output coreStrobe_t [NUM_CORES-1:0] stb,
  output logic [NUM_CORES-1:0] ifaceEn,
  output logic [NUM_CORES-1:0][SGI_N-1:0][PRIO_W-1:0] sgiPrio,
  output logic [NUM_CORES-1:0][SGI_N-1:0] sgiEn,
  output logic [NUM_CORES-1:0][PPI_N-1:0][PRIO_W-1:0] ppiPrio,
  output logic [NUM_CORES-1:0][PPI_N-1:0] ppiEn,
  output logic [NUM_SPI-1:0][PRIO_W-1:0] spiPrio,
  output logic [NUM_SPI-1:0] spiEn,
  output logic [NUM_SPI-1:0][NUM_CORES-1:0] spiTarget,
  output logic [NUM_SPI-1:0] spiEdge
);
  localparam logic [ID_W-1:0] ID_SGI_END = ID_W'(SGI_N);
  localparam logic [ID_W-1:0] ID_PPI_LO  = ID_W'(PPI_BASE);
  localparam logic [ID_W-1:0] ID_SPI_LO  = ID_W'(SPI_BASE);
  localparam logic [ID_W-1:0] ID_SPI_END = ID_W'(SPI_BASE + NUM_SPI);

  logic inSgi, inPpi, inSpi, coreOk;
  logic [2:0] ppiIdx;
  logic [SPI_IW-1:0] spiIdx;
  logic [ID_W-1:0] spiOff;

  assign inSgi  = cfgId < ID_SGI_END;
  assign inPpi  = (cfgId >= ID_PPI_LO) && (cfgId < ID_SPI_LO);
  assign inSpi  = (cfgId >= ID_SPI_LO) && (cfgId < ID_SPI_END);
  assign coreOk = 32'(cfgCore) < NUM_CORES;
  assign ppiIdx = cfgId[2:0] - 3'd3;
  assign spiOff = cfgId - ID_SPI_LO;
  assign spiIdx = spiOff[SPI_IW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ifaceEn   <= '0;
      sgiPrio   <= '0;
      sgiEn     <= '0;
      ppiPrio   <= '0;
      ppiEn     <= '0;
      spiPrio   <= '0;
      spiEn     <= '0;
      spiTarget <= '0;
      spiEdge   <= '0;
    end else if (cfgWe && coreOk) begin
      case (cfgSel_e'(cfgSel))
        SEL_PRIO: begin
          if (inSgi)      sgiPrio[cfgCore][cfgId[3:0]] <= cfgData[PRIO_W-1:0];
          else if (inPpi) ppiPrio[cfgCore][ppiIdx]     <= cfgData[PRIO_W-1:0];
          else if (inSpi) spiPrio[spiIdx]              <= cfgData[PRIO_W-1:0];
        end
        SEL_ENABLE: begin
          if (inSgi)      sgiEn[cfgCore][cfgId[3:0]] <= cfgData[0];
          else if (inPpi) ppiEn[cfgCore][ppiIdx]     <= cfgData[0];
          else if (inSpi) spiEn[spiIdx]              <= cfgData[0];
        end
        SEL_TARGET: if (inSpi) spiTarget[spiIdx] <= cfgData[NUM_CORES-1:0];
        SEL_TRIG:   if (inSpi) spiEdge[spiIdx]   <= cfgData[0];
        SEL_IFACE:  ifaceEn[cfgCore] <= cfgData[0];
        default: ;
      endcase
    end
  end

  // strobes: software interrupts go by receiver mask, so the writer's own core number plays no part
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_stb
    assign stb[c].ack    = ackReq[c];
    assign stb[c].eoi    = eoiReq[c];
    assign stb[c].eoiId  = eoiIdIn[c*ID_W +: ID_W];
    assign stb[c].sgiSet = (cfgWe && cfgSel == SEL_SGI && inSgi && cfgData[c])
                           ? (SGI_N'(1) << cfgId[3:0]) : '0;
  end
endmodule

// File: rtl/irqd_path.sv
module irqd_path
  import irqd_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int NUM_SPI   = 8,
  parameter int PRIO_W    = 4,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int SPI_IW   = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  coreStrobe_t [NUM_CORES-1:0] stb,
  input  logic [NUM_CORES-1:0] ifaceEn,
  input  logic [NUM_CORES-1:0][SGI_N-1:0][PRIO_W-1:0] sgiPrio,
  input  logic [NUM_CORES-1:0][SGI_N-1:0] sgiEn,
  input  logic [NUM_CORES-1:0][PPI_N-1:0][PRIO_W-1:0] ppiPrio,
  input  logic [NUM_CORES-1:0][PPI_N-1:0] ppiEn,
  input  logic [NUM_SPI-1:0][PRIO_W-1:0] spiPrio,
  input  logic [NUM_SPI-1:0] spiEn,
  input  logic [NUM_SPI-1:0][NUM_CORES-1:0] spiTarget,
  input  logic [NUM_SPI-1:0] spiEdge,
  input  logic [NUM_SPI-1:0] spiIn,
  input  logic [NUM_CORES-1:0][PPI_N-1:0] ppiLines,
  input  logic [NUM_CORES-1:0] legacyIrq,
  output logic [NUM_CORES-1:0] coreIrq,
  output logic [NUM_CORES-1:0][ID_W-1:0] coreIrqId,
  output logic [NUM_CORES-1:0][ID_W-1:0] ackId
);
  localparam logic [ID_W-1:0] ID_SGI_END = ID_W'(SGI_N);
  localparam logic [ID_W-1:0] ID_PPI_LO  = ID_W'(PPI_BASE);
  localparam logic [ID_W-1:0] ID_SPI_LO  = ID_W'(SPI_BASE);
  localparam logic [ID_W-1:0] ID_SPI_END = ID_W'(SPI_BASE + NUM_SPI);

  logic [NUM_CORES-1:0][SGI_N-1:0] sgiPend, sgiAct, sgiPendN, sgiActN, sgiAckClr;
  logic [NUM_CORES-1:0][PPI_N-1:0] ppiPend, ppiAct, ppiPendN, ppiActN;
  logic [NUM_SPI-1:0] spiPend, spiAct, spiPrev, spiPendN, spiActN, spiAckClr;
  logic [NUM_SPI-1:0][CORE_W-1:0] spiOwner, spiOwnerN;
  logic [NUM_SPI-1:0][NUM_CORES-1:0] spiRoute;
  logic [NUM_CORES-1:0] idle, deliver;
  logic [NUM_CORES-1:0][ID_W-1:0] bestId;

  // a core is idle when it owns no active source
  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      idle[c] = !(|sgiAct[c]) && !(|ppiAct[c]);
      for (int j = 0; j < NUM_SPI; j++)
        if (spiAct[j] && spiOwner[j] == CORE_W'(c)) idle[c] = 1'b0;
    end
  end

  // 1-of-N: lowest-numbered idle target with an enabled interface
  always_comb begin
    logic taken;
    spiRoute = '0;
    for (int j = 0; j < NUM_SPI; j++) begin
      taken = 1'b0;
      for (int c = 0; c < NUM_CORES; c++)
        if (!taken && spiTarget[j][c] && idle[c] && ifaceEn[c]) begin
          spiRoute[j][c] = 1'b1;
          taken = 1'b1;
        end
    end
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    logic fnd;
    logic [PRIO_W-1:0] bP;
    logic [ID_W-1:0] bId;
    logic [ID_W-1:0] ackIdR;

    // ascending scan with strict compare: ties keep the lower number
    always_comb begin
      fnd = 1'b0;
      bP  = '1;
      bId = SPURIOUS_ID;
      for (int i = 0; i < SGI_N; i++)
        if (sgiPend[g][i] && !sgiAct[g][i] && sgiEn[g][i] && (!fnd || sgiPrio[g][i] < bP)) begin
          fnd = 1'b1; bP = sgiPrio[g][i]; bId = ID_W'(i);
        end
      for (int i = 0; i < PPI_N; i++)
        if (ppiPend[g][i] && !ppiAct[g][i] && ppiEn[g][i] && (!fnd || ppiPrio[g][i] < bP)) begin
          fnd = 1'b1; bP = ppiPrio[g][i]; bId = ID_W'(PPI_BASE + i);
        end
      for (int j = 0; j < NUM_SPI; j++)
        if (spiPend[j] && !spiAct[j] && spiEn[j] && spiRoute[j][g] && (!fnd || spiPrio[j] < bP)) begin
          fnd = 1'b1; bP = spiPrio[j]; bId = ID_W'(SPI_BASE + j);
        end
    end

    assign deliver[g]   = ifaceEn[g] && idle[g] && fnd;
    assign bestId[g]    = bId;
    assign coreIrq[g]   = ifaceEn[g] ? deliver[g] : legacyIrq[g];
    assign coreIrqId[g] = deliver[g] ? bId : SPURIOUS_ID;
    assign ackId[g]     = ackIdR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          ackIdR <= SPURIOUS_ID;
      else if (stb[g].ack) ackIdR <= deliver[g] ? bId : SPURIOUS_ID;
    end

    AST_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rstN)
      stb[g].ack && !deliver[g] |=> ackIdR == SPURIOUS_ID); // R9
    AST_ACK_BUSY: assert property (@(posedge clk) disable iff (!rstN)
      stb[g].ack && deliver[g] |=> !deliver[g]); // R8
  end

  // state transitions: end-of-interrupt first, then acknowledge
  always_comb begin
    logic [ID_W-1:0] id;
    logic [ID_W-1:0] off;
    logic [SPI_IW-1:0] sIdx;
    id = '0; off = '0; sIdx = '0;
    sgiActN = sgiAct; ppiActN = ppiAct; spiActN = spiAct; spiOwnerN = spiOwner;
    sgiAckClr = '0; spiAckClr = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (stb[c].eoi) begin
        id = stb[c].eoiId; off = id - ID_SPI_LO; sIdx = off[SPI_IW-1:0];
        if (id < ID_SGI_END) sgiActN[c][id[3:0]] = 1'b0;
        else if (id >= ID_PPI_LO && id < ID_SPI_LO) ppiActN[c][id[2:0] - 3'd3] = 1'b0;
        else if (id >= ID_SPI_LO && id < ID_SPI_END && spiOwner[sIdx] == CORE_W'(c))
          spiActN[sIdx] = 1'b0;
      end
      if (stb[c].ack && deliver[c]) begin
        id = bestId[c]; off = id - ID_SPI_LO; sIdx = off[SPI_IW-1:0];
        if (id < ID_SGI_END) begin
          sgiActN[c][id[3:0]] = 1'b1; sgiAckClr[c][id[3:0]] = 1'b1;
        end else if (id < ID_SPI_LO) begin
          ppiActN[c][id[2:0] - 3'd3] = 1'b1;
        end else begin
          spiActN[sIdx] = 1'b1; spiAckClr[sIdx] = 1'b1; spiOwnerN[sIdx] = CORE_W'(c);
        end
      end
    end
    for (int c = 0; c < NUM_CORES; c++) begin
      sgiPendN[c] = (sgiPend[c] & ~sgiAckClr[c]) | stb[c].sgiSet;
      ppiPendN[c] = ppiLines[c] & ~ppiActN[c];
    end
    for (int j = 0; j < NUM_SPI; j++)
      spiPendN[j] = spiEdge[j] ? ((spiPend[j] && !spiAckClr[j]) || (spiIn[j] && !spiPrev[j]))
                               : (spiIn[j] && !spiActN[j]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sgiPend <= '0; sgiAct <= '0; ppiPend <= '0; ppiAct <= '0;
      spiPend <= '0; spiAct <= '0; spiPrev <= '0; spiOwner <= '0;
    end else begin
      sgiPend <= sgiPendN; sgiAct <= sgiActN; ppiPend <= ppiPendN; ppiAct <= ppiActN;
      spiPend <= spiPendN; spiAct <= spiActN; spiPrev <= spiIn; spiOwner <= spiOwnerN;
    end
  end

  for (genvar j = 0; j < NUM_SPI; j++) begin : g_spiChk
    AST_LEVEL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
      $past(!spiEdge[j]) && spiAct[j] |-> !spiPend[j]); // R6
  end

  for (genvar a = 0; a < NUM_CORES; a++) begin : g_pairA
    for (genvar b = a + 1; b < NUM_CORES; b++) begin : g_pairB
      AST_ONE_TAKER: assert property (@(posedge clk) disable iff (!rstN)
        !(deliver[a] && deliver[b] && bestId[a] == bestId[b] && bestId[a] >= ID_SPI_LO)); // R7
    end
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqd_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int NUM_SPI   = 8,
  parameter int PRIO_W    = 4,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic [NUM_SPI-1:0] spiIn,
  input  logic [NUM_CORES-1:0] glbTimer,
  input  logic [NUM_CORES-1:0] legacyFiq,
  input  logic [NUM_CORES-1:0] privTimer,
  input  logic [NUM_CORES-1:0] wdogIrq,
  input  logic [NUM_CORES-1:0] legacyIrq,
  input  logic cfgWe,
  input  logic [CORE_W-1:0] cfgCore,
  input  logic [2:0] cfgSel,
  input  logic [9:0] cfgId,
  input  logic [7:0] cfgData,
  input  logic [NUM_CORES-1:0] ackReq,
  input  logic [NUM_CORES-1:0] eoiReq,
  input  logic [NUM_CORES*10-1:0] eoiIdIn,
  output logic [NUM_CORES-1:0] coreIrq,
  output logic [NUM_CORES*10-1:0] coreIrqId,
  output logic [NUM_CORES*10-1:0] ackId
);
  coreStrobe_t [NUM_CORES-1:0] stb;
  logic [NUM_CORES-1:0] ifaceEn;
  logic [NUM_CORES-1:0][SGI_N-1:0][PRIO_W-1:0] sgiPrio;
  logic [NUM_CORES-1:0][SGI_N-1:0] sgiEn;
  logic [NUM_CORES-1:0][PPI_N-1:0][PRIO_W-1:0] ppiPrio;
  logic [NUM_CORES-1:0][PPI_N-1:0] ppiEn;
  logic [NUM_SPI-1:0][PRIO_W-1:0] spiPrio;
  logic [NUM_SPI-1:0] spiEn, spiEdge;
  logic [NUM_SPI-1:0][NUM_CORES-1:0] spiTarget;
  logic [NUM_CORES-1:0][PPI_N-1:0] ppiLines;
  logic [NUM_CORES-1:0][ID_W-1:0] irqIdArr, ackIdArr;

  // private line order follows the fixed numbers 27..31
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_ppi
    assign ppiLines[c] = {legacyIrq[c], wdogIrq[c], privTimer[c], legacyFiq[c], glbTimer[c]};
  end

  irqd_ctrl #(.NUM_CORES(NUM_CORES), .NUM_SPI(NUM_SPI), .PRIO_W(PRIO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgCore(cfgCore), .cfgSel(cfgSel),
    .cfgId(cfgId), .cfgData(cfgData), .ackReq(ackReq), .eoiReq(eoiReq), .eoiIdIn(eoiIdIn),
    .stb(stb), .ifaceEn(ifaceEn), .sgiPrio(sgiPrio), .sgiEn(sgiEn), .ppiPrio(ppiPrio),
    .ppiEn(ppiEn), .spiPrio(spiPrio), .spiEn(spiEn), .spiTarget(spiTarget), .spiEdge(spiEdge)
  );

  irqd_path #(.NUM_CORES(NUM_CORES), .NUM_SPI(NUM_SPI), .PRIO_W(PRIO_W)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .ifaceEn(ifaceEn), .sgiPrio(sgiPrio), .sgiEn(sgiEn),
    .ppiPrio(ppiPrio), .ppiEn(ppiEn), .spiPrio(spiPrio), .spiEn(spiEn), .spiTarget(spiTarget),
    .spiEdge(spiEdge), .spiIn(spiIn), .ppiLines(ppiLines), .legacyIrq(legacyIrq),
    .coreIrq(coreIrq), .coreIrqId(irqIdArr), .ackId(ackIdArr)
  );

  assign coreIrqId = irqIdArr;
  assign ackId     = ackIdArr;
endmodule

// File: tb/irq_distributor_test.sv
module irq_distributor_test;
  localparam int NC = 2;
  localparam int NS = 8;
  localparam logic [2:0] S_PRIO = 3'd0, S_EN = 3'd1, S_TGT = 3'd2, S_TRIG = 3'd3,
                         S_SGI = 3'd4, S_IF = 3'd5;
  // {prio of 32, prio of 33, prio of 30 (watchdog), expected number on core 0}
  localparam int VEC [0:5][0:3] = '{
    '{3, 5, 7, 32}, '{5, 3, 7, 33}, '{4, 4, 9, 32},
    '{6, 6, 6, 30}, '{9, 2, 2, 30}, '{8, 1, 2, 33}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] spiIn = '0;
  logic [NC-1:0] glbTimer = '0, legacyFiq = '0, privTimer = '0, wdogIrq = '0, legacyIrq = '0;
  logic cfgWe = 1'b0;
  logic [0:0] cfgCore = '0;
  logic [2:0] cfgSel = '0;
  logic [9:0] cfgId = '0;
  logic [7:0] cfgData = '0;
  logic [NC-1:0] ackReq = '0, eoiReq = '0;
  logic [NC*10-1:0] eoiIdIn = '0;
  logic [NC-1:0] coreIrq;
  logic [NC*10-1:0] coreIrqId, ackId;
  int nTests = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  irq_distributor #(.NUM_CORES(NC), .NUM_SPI(NS), .PRIO_W(4)) uut (
    .clk(clk), .rstN(rstN), .spiIn(spiIn), .glbTimer(glbTimer), .legacyFiq(legacyFiq),
    .privTimer(privTimer), .wdogIrq(wdogIrq), .legacyIrq(legacyIrq), .cfgWe(cfgWe),
    .cfgCore(cfgCore), .cfgSel(cfgSel), .cfgId(cfgId), .cfgData(cfgData), .ackReq(ackReq),
    .eoiReq(eoiReq), .eoiIdIn(eoiIdIn), .coreIrq(coreIrq), .coreIrqId(coreIrqId), .ackId(ackId));

  task automatic chk(input string tag, input int act, input int exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] sel, input int core, input int id, input int data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgCore = 1'(core); cfgId = 10'(id); cfgData = 8'(data);
    @(posedge clk); @(negedge clk);
    cfgWe = 1'b0; #1;
  endtask

  task automatic ack(input int c);
    @(negedge clk); ackReq[c] = 1'b1;
    @(posedge clk); @(negedge clk); ackReq[c] = 1'b0; #1;
  endtask

  task automatic eoi(input int c, input int id);
    @(negedge clk); eoiReq[c] = 1'b1; eoiIdIn[c*10 +: 10] = 10'(id);
    @(posedge clk); @(negedge clk); eoiReq[c] = 1'b0; #1;
  endtask

  function automatic int idOf(input int c);
    return int'(coreIrqId[c*10 +: 10]);
  endfunction
  function automatic int ackOf(input int c);
    return int'(ackId[c*10 +: 10]);
  endfunction

  initial begin
    #(4 * 100000);
    nFail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1; #1;
    // R1 reset state
    chk("R1 coreIrq", int'(coreIrq), 0);
    chk("R1 ackId0", ackOf(0), 1023);
    chk("R1 ackId1", ackOf(1), 1023);
    chk("R1 irqId0", idOf(0), 1023);

    // R2 bypass while interface disabled
    legacyIrq[1] = 1'b1; #1;
    chk("R2 bypass high", int'(coreIrq[1]), 1);
    legacyIrq[1] = 1'b0; #1;
    chk("R2 bypass low", int'(coreIrq[1]), 0);

    wr(S_IF, 0, 0, 1);
    wr(S_IF, 1, 0, 1);

    // R2/R5 legacy IRQ becomes number 31 once the interface is on
    legacyIrq[0] = 1'b1; step();
    chk("R2 legacy not bypassed", int'(coreIrq[0]), 0);
    wr(S_EN, 0, 31, 1);
    chk("R5 legacy irq req", int'(coreIrq[0]), 1);
    chk("R5 legacy irq id 31", idOf(0), 31);
    legacyIrq[0] = 1'b0; step();
    chk("R5 level drop", int'(coreIrq[0]), 0);
    wr(S_EN, 1, 27, 1);
    glbTimer[1] = 1'b1; step();
    chk("R5 global timer id 27", idOf(1), 27);
    glbTimer[1] = 1'b0; step();

    // R3 priority table
    wr(S_EN, 0, 32, 1); wr(S_TGT, 0, 32, 1);
    wr(S_EN, 0, 33, 1); wr(S_TGT, 0, 33, 1);
    wr(S_EN, 0, 30, 1);
    spiIn[0] = 1'b1; spiIn[1] = 1'b1; wdogIrq[0] = 1'b1;
    for (int v = 0; v < 6; v++) begin
      wr(S_PRIO, 0, 32, VEC[v][0]);
      wr(S_PRIO, 0, 33, VEC[v][1]);
      wr(S_PRIO, 0, 30, VEC[v][2]);
      chk($sformatf("R3 vector %0d", v), idOf(0), VEC[v][3]);
    end
    spiIn[0] = 1'b0; spiIn[1] = 1'b0; wdogIrq[0] = 1'b0; step();
    chk("R6 level lines drop", int'(coreIrq[0]), 0);

    // R4 banked software priority
    wr(S_PRIO, 0, 5, 7); wr(S_PRIO, 1, 5, 2); wr(S_PRIO, 1, 3, 6);
    wr(S_EN, 0, 5, 1); wr(S_EN, 1, 5, 1); wr(S_EN, 1, 3, 1);
    wr(S_SGI, 0, 5, 3);
    wr(S_SGI, 0, 3, 2);
    chk("R4 core1 receiver bank", idOf(1), 5);
    chk("R4 core0 alias", idOf(0), 5);

    // R8 / R9 acknowledge
    ack(1);
    chk("R8 ackId", ackOf(1), 5);
    chk("R8 busy drops req", int'(coreIrq[1]), 0);
    ack(1);
    chk("R9 ack while busy", ackOf(1), 1023);
    eoi(1, 5);
    chk("R10 next offered", idOf(1), 3);
    ack(1); eoi(1, 3);
    ack(0); eoi(0, 5);
    chk("R8 core0 empty", int'(coreIrq[0]), 0);
    ack(0);
    chk("R9 spurious", ackOf(0), 1023);

    // R7 1-of-N with edge trigger
    wr(S_PRIO, 0, 34, 1); wr(S_TRIG, 0, 34, 1); wr(S_TGT, 0, 34, 3); wr(S_EN, 0, 34, 1);
    wr(S_SGI, 0, 5, 1);
    ack(0);
    spiIn[2] = 1'b1; step(); spiIn[2] = 1'b0;
    chk("R7 goes to idle core1", idOf(1), 34);
    chk("R7 busy core0 none", int'(coreIrq[0]), 0);
    ack(1);
    chk("R6 edge ack id 34", ackOf(1), 34);
    eoi(0, 5);
    chk("R7 not offered to other", int'(coreIrq[0]), 0);
    spiIn[2] = 1'b1; step(); spiIn[2] = 1'b0; step();
    chk("R10 active+pending held", int'(coreIrq[0]), 0);
    eoi(1, 34);
    chk("R10 edge re-offered", idOf(0), 34);
    chk("R7 single taker", int'(coreIrq[1]), 0);
    ack(0); eoi(0, 34); step();
    chk("R6 edge no re-pend", int'(coreIrq[0]), 0);

    // R10 level still high after end-of-interrupt
    wr(S_PRIO, 0, 35, 0); wr(S_TGT, 0, 35, 2); wr(S_EN, 0, 35, 1);
    spiIn[3] = 1'b1; step();
    chk("R6 level id 35", idOf(1), 35);
    ack(1);
    chk("R8 ack 35", ackOf(1), 35);
    eoi(1, 35);
    chk("R10 level re-pend", idOf(1), 35);
    spiIn[3] = 1'b0; step();
    chk("R6 level gone", int'(coreIrq[1]), 0);

    // R11 disabled source and empty target mask
    wr(S_TGT, 0, 36, 1);
    spiIn[4] = 1'b1; step();
    chk("R11 disabled", int'(coreIrq[0]), 0);
    wr(S_EN, 0, 37, 1);
    spiIn[5] = 1'b1; step();
    chk("R11 no target", int'(coreIrq), 0);
    spiIn[4] = 1'b0; spiIn[5] = 1'b0; step();

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule